// File: doc/BRIEF.md
# Conversion Trigger Preemption Scheduler

This block decides which conversion command a converter front end runs next when several prioritized triggers compete. Each trigger owns a sequence of commands stored in a fixed slot of an external command table; the block walks that sequence, issues one start strobe per conversion, counts the averaging group and loop repetitions of the current command from its descriptor, and moves to the next command until a command flagged as last completes. Pending triggers are served lowest index first.

When a trigger of strictly higher priority arrives while a sequence runs, a two-bit preemption mode selects where the switch happens: at once with an abort strobe (0), after the current averaging group with remaining loops skipped (1), or after the whole command (2, with the reserved value 3 acting the same). A disable bit turns preemption off. The interrupted sequence is either dropped with a one-cycle status pulse, or stored in a single saved slot and later restarted from its first command or resumed at the interrupted command. Only one saved slot exists, so a further higher trigger during a preempting sequence waits in the pending set.

Top module: `trig_preempt_sched`

## Requirements
- R1: After reset no start, abort, result or drop strobe is raised until a trigger is pulsed; start and abort are never raised together.
- R2: A pulse on `trig_i[t]` is held pending; when idle, the lowest pending index starts first and its first command index is t*SEQ_LEN (`conv_cmd_o` = {t, zeros}).
- R3: A command runs (avg+1)*(loop+1) conversions, one start strobe each, then the next command index follows; the sequence ends after a command with `cmd_last_i` = 1. `result_valid_o` follows `conv_done_i` only while a conversion is outstanding.
- R4: Mode 0 (`cfg_i[1:0]`=0): a higher-priority pending trigger causes a one-cycle abort strobe, followed in the next cycle by the start of the new trigger's first command; the aborted conversion yields no result.
- R5: Mode 1: the switch occurs after the conversion that closes the current averaging group; the remaining loop repetitions of that command are skipped.
- R6: Mode 2 and reserved mode 3: the switch occurs only after the current command has completed all its conversions.
- R7: With `cfg_i[10]` = 1 no preemption and no abort happen; a waiting higher trigger starts after the running sequence ends, ahead of lower pending triggers.
- R8: With `cfg_i[8]` = 0 the interrupted sequence is abandoned and `seq_drop_o` pulses for exactly one cycle at the switch.
- R9: With `cfg_i[8]` = 1 and `cfg_i[9]` = 0, after the preempting sequence ends the interrupted one restarts at its first command.
- R10: With `cfg_i[8]` = 1 and `cfg_i[9]` = 1 the interrupted sequence resumes at the command that was running, from its first conversion, or at the following command if that command had just completed.
- R11: While a saved context exists, no further preemption occurs; at sequence end a pending trigger of higher priority than the saved one runs before the saved one is restored.
- R12: A pending trigger of equal or lower priority than the running one never interrupts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_i | input | 11 | Configuration word: [1:0] mode, [8] resume enable, [9] resume at interrupted command, [10] preemption disable |
| trig_i | input | NTRIG | One-cycle trigger request pulses, index 0 highest priority |
| conv_start_o | output | 1 | Start one conversion of `conv_cmd_o` |
| conv_abort_o | output | 1 | Abort the conversion in flight |
| conv_cmd_o | output | log2(NTRIG)+log2(SEQ_LEN) | Active command index, also the descriptor lookup address |
| conv_done_i | input | 1 | Conversion finished pulse from the engine |
| cmd_avg_i | input | AVGW | Descriptor: conversions per averaging group minus one |
| cmd_loop_i | input | LOOPW | Descriptor: averaging groups per command minus one |
| cmd_last_i | input | 1 | Descriptor: command ends its sequence |
| result_valid_o | output | 1 | A conversion result is valid |
| seq_drop_o | output | 1 | One-cycle pulse: an interrupted sequence was abandoned |

## Verification
The checker watches every cycle that an abort is a single cycle followed by a start, that no result appears during an abort, that aborts only occur in mode 0 with preemption enabled, that start and drop strobes are single cycles and that results only accompany engine completions. Which command runs when, how many conversions a command gets before a switch, and whether the interrupted sequence comes back at its first command, its interrupted command or not at all can only be shown by the bench scenarios, which compare the full ordered stream of start, abort and drop events against the expected one for each mode and resume setting, including a queued second preemption.

// File: rtl/trig_preempt_pkg.sv
package trig_preempt_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_WAIT, ST_ABORT} sched_st_e;

  localparam int CFG_W           = 11;
  localparam int CFG_RESUME_BIT  = 8;
  localparam int CFG_CMDRES_BIT  = 9;
  localparam int CFG_NOPRE_BIT   = 10;

  localparam logic [1:0] MODE_ABORT = 2'd0;
  localparam logic [1:0] MODE_GROUP = 2'd1;
endpackage

// File: rtl/trig_pri_pick.sv
module trig_pri_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/conv_progress.sv
module conv_progress #(
  parameter int AVGW  = 3,
  parameter int LOOPW = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic [AVGW-1:0]  avg_lim,
  input  logic [LOOPW-1:0] loop_lim,
  output logic             grp_end,
  output logic             cmd_end
);
  logic [AVGW-1:0]  avg_q, avg_d;
  logic [LOOPW-1:0] loop_q, loop_d;

  assign grp_end = step && (avg_q == avg_lim);
  assign cmd_end = grp_end && (loop_q == loop_lim);

  always_comb begin
    avg_d  = avg_q;
    loop_d = loop_q;
    if (clr) begin
      avg_d  = '0;
      loop_d = '0;
    end else if (step) begin
      if (avg_q == avg_lim) begin
        avg_d  = '0;
        loop_d = loop_q + 1'b1;
      end else begin
        avg_d = avg_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      avg_q  <= '0;
      loop_q <= '0;
    end else if (clr || step) begin
      avg_q  <= avg_d;
      loop_q <= loop_d;
    end
  end
endmodule

// File: rtl/ctx_slot.sv
module ctx_slot #(
  parameter int TW = 2,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          save,
  input  logic          take,
  input  logic [TW-1:0] d_trig,
  input  logic [CW-1:0] d_cmd,
  output logic          valid,
  output logic [TW-1:0] trig,
  output logic [CW-1:0] cmd
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
    end else if (save || take) begin
      valid <= save;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig <= '0;
      cmd  <= '0;
    end else if (save) begin
      trig <= d_trig;
      cmd  <= d_cmd;
    end
  end
endmodule

// File: rtl/trig_preempt_sched.sv
module trig_preempt_sched
  import trig_preempt_pkg::*;
#(
  parameter int NTRIG   = 4,
  parameter int SEQ_LEN = 4,
  parameter int AVGW    = 3,
  parameter int LOOPW   = 3,
  localparam int TW = (NTRIG > 1) ? $clog2(NTRIG) : 1,
  localparam int SW = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1,
  localparam int CW = TW + SW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [10:0]      cfg_i,
  input  logic [NTRIG-1:0] trig_i,
  output logic             conv_start_o,
  output logic             conv_abort_o,
  output logic [CW-1:0]    conv_cmd_o,
  input  logic             conv_done_i,
  input  logic [AVGW-1:0]  cmd_avg_i,
  input  logic [LOOPW-1:0] cmd_loop_i,
  input  logic             cmd_last_i,
  output logic             result_valid_o,
  output logic             seq_drop_o
);
  sched_st_e        state_q, state_d;
  logic [TW-1:0]    trig_q, trig_d;
  logic [CW-1:0]    cmd_q, cmd_d;
  logic [NTRIG-1:0] pend_q, pend_d, pend_clr;
  logic             drop_q, drop_d;

  logic             hi_any;
  logic [TW-1:0]    hi_idx;
  logic             step, grp_end, cmd_end, clr;
  logic             sav_valid, save, take;
  logic [TW-1:0]    sav_trig;
  logic [CW-1:0]    sav_cmd, sv_cmd;
  logic             cand, pre_pt;
  logic [1:0]       mode;
  logic             unused_cfg;

  assign mode       = cfg_i[1:0];
  assign unused_cfg = ^cfg_i[7:2];

  trig_pri_pick #(.N(NTRIG), .IW(TW)) u_pick (
    .req(pend_q), .any(hi_any), .idx(hi_idx)
  );

  assign step = (state_q == ST_WAIT) && conv_done_i;

  conv_progress #(.AVGW(AVGW), .LOOPW(LOOPW)) u_prog (
    .clk(clk), .rst_n(rst_n), .clr(clr), .step(step),
    .avg_lim(cmd_avg_i), .loop_lim(cmd_loop_i),
    .grp_end(grp_end), .cmd_end(cmd_end)
  );

  ctx_slot #(.TW(TW), .CW(CW)) u_ctx (
    .clk(clk), .rst_n(rst_n), .save(save), .take(take),
    .d_trig(trig_q), .d_cmd(sv_cmd),
    .valid(sav_valid), .trig(sav_trig), .cmd(sav_cmd)
  );

  // strictly higher priority, enabled, and the single save slot is free
  assign cand = hi_any && (hi_idx < trig_q) && !cfg_i[CFG_NOPRE_BIT] && !sav_valid;

  always_comb begin
    case (mode)
      MODE_ABORT: pre_pt = cand;
      MODE_GROUP: pre_pt = cand && grp_end;
      default:    pre_pt = cand && cmd_end;
    endcase
  end

  always_comb begin
    if (!cfg_i[CFG_CMDRES_BIT])   sv_cmd = {trig_q, {SW{1'b0}}};
    else if (cmd_end)             sv_cmd = CW'(cmd_q + 1'b1);
    else                          sv_cmd = cmd_q;
  end

  always_comb begin
    state_d  = state_q;
    trig_d   = trig_q;
    cmd_d    = cmd_q;
    pend_clr = '0;
    drop_d   = 1'b0;
    clr      = 1'b0;
    save     = 1'b0;
    take     = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (hi_any) begin
          trig_d           = hi_idx;
          cmd_d            = {hi_idx, {SW{1'b0}}};
          pend_clr[hi_idx] = 1'b1;
          clr              = 1'b1;
          state_d          = ST_START;
        end
      end
      ST_START: state_d = ST_WAIT;
      ST_WAIT: begin
        if (step && cmd_end && cmd_last_i) begin
          clr = 1'b1;
          if (sav_valid && !(hi_any && (hi_idx < sav_trig))) begin
            take    = 1'b1;
            trig_d  = sav_trig;
            cmd_d   = sav_cmd;
            state_d = ST_START;
          end else if (hi_any) begin
            trig_d           = hi_idx;
            cmd_d            = {hi_idx, {SW{1'b0}}};
            pend_clr[hi_idx] = 1'b1;
            state_d          = ST_START;
          end else begin
            state_d = ST_IDLE;
          end
        end else if (pre_pt) begin
          clr              = 1'b1;
          save             = cfg_i[CFG_RESUME_BIT];
          drop_d           = !cfg_i[CFG_RESUME_BIT];
          trig_d           = hi_idx;
          cmd_d            = {hi_idx, {SW{1'b0}}};
          pend_clr[hi_idx] = 1'b1;
          state_d          = step ? ST_START : ST_ABORT;
        end else if (step && cmd_end) begin
          clr     = 1'b1;
          cmd_d   = CW'(cmd_q + 1'b1);
          state_d = ST_START;
        end else if (step) begin
          state_d = ST_START;
        end
      end
      default: state_d = ST_START;
    endcase
    pend_d = (pend_q & ~pend_clr) | trig_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      trig_q  <= '0;
      cmd_q   <= '0;
      pend_q  <= '0;
      drop_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      trig_q  <= trig_d;
      cmd_q   <= cmd_d;
      pend_q  <= pend_d;
      drop_q  <= drop_d;
    end
  end

  assign conv_start_o   = (state_q == ST_START);
  assign conv_abort_o   = (state_q == ST_ABORT);
  assign conv_cmd_o     = cmd_q;
  assign result_valid_o = step;
  assign seq_drop_o     = drop_q;
endmodule

// File: rtl/trig_preempt_sched_chk.sv
module trig_preempt_sched_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [10:0] cfg_i,
  input logic        conv_start_o,
  input logic        conv_abort_o,
  input logic        conv_done_i,
  input logic        result_valid_o,
  input logic        seq_drop_o
);
  // R1
  a_r1_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(conv_start_o && conv_abort_o));
  // R3
  a_r3_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_o |=> !conv_start_o);
  // R3
  a_r3_result_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid_o |-> conv_done_i);
  // R4
  a_r4_abort_then_start: assert property (@(posedge clk) disable iff (!rst_n)
    conv_abort_o |=> (conv_start_o && !conv_abort_o));
  // R4
  a_r4_no_result_on_abort: assert property (@(posedge clk) disable iff (!rst_n)
    conv_abort_o |-> !result_valid_o);
  // R7
  a_r7_abort_only_mode0: assert property (@(posedge clk) disable iff (!rst_n)
    conv_abort_o |-> ($past(cfg_i[1:0]) == 2'd0 && !$past(cfg_i[10])));
  // R8
  a_r8_drop_single: assert property (@(posedge clk) disable iff (!rst_n)
    seq_drop_o |=> !seq_drop_o);
endmodule

bind trig_preempt_sched trig_preempt_sched_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_i(cfg_i),
  .conv_start_o(conv_start_o), .conv_abort_o(conv_abort_o),
  .conv_done_i(conv_done_i), .result_valid_o(result_valid_o),
  .seq_drop_o(seq_drop_o)
);

// File: tb/trig_preempt_sched_tb_top.sv
`timescale 1ns/1ps
module trig_preempt_sched_tb_top;
  localparam int LAT = 3;
  localparam int EV_ABORT = 100;
  localparam int EV_DROP  = 200;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [10:0] cfg_i;
  logic [3:0]  trig_i;
  logic        conv_start_o, conv_abort_o, conv_done_i;
  logic [3:0]  conv_cmd_o;
  logic [2:0]  cmd_avg_i, cmd_loop_i;
  logic        cmd_last_i, result_valid_o, seq_drop_o;

  int    n_chk = 0, n_fail = 0, n_res = 0, quiet = 0;
  int    exp_q[$];
  string cur_req = "R1";

  always #10 clk = ~clk;

  trig_preempt_sched dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_i(cfg_i), .trig_i(trig_i),
    .conv_start_o(conv_start_o), .conv_abort_o(conv_abort_o),
    .conv_cmd_o(conv_cmd_o), .conv_done_i(conv_done_i),
    .cmd_avg_i(cmd_avg_i), .cmd_loop_i(cmd_loop_i), .cmd_last_i(cmd_last_i),
    .result_valid_o(result_valid_o), .seq_drop_o(seq_drop_o)
  );

  // command table: slots of 4 per trigger
  always_comb begin
    cmd_avg_i  = 3'd0;
    cmd_loop_i = 3'd0;
    cmd_last_i = 1'b0;
    case (conv_cmd_o)
      4'd5:  begin cmd_avg_i = 3'd1; cmd_loop_i = 3'd2; end
      4'd8:  cmd_avg_i = 3'd1;
      4'd0, 4'd4: ;
      default: cmd_last_i = 1'b1;
    endcase
  end

  // conversion engine model
  initial begin
    bit s, a, busy;
    int cnt;
    busy = 0; cnt = 0; conv_done_i = 1'b0;
    forever begin
      @(negedge clk);
      s = conv_start_o; a = conv_abort_o;
      @(posedge clk); #1;
      conv_done_i = 1'b0;
      if (!rst_n || a) busy = 0;
      else if (s) begin busy = 1; cnt = LAT; end
      else if (busy) begin
        cnt--;
        if (cnt == 0) begin conv_done_i = 1'b1; busy = 0; end
      end
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", cur_req, what, act, exp);
    end
  endtask

  task automatic pop_cmp(input int ev);
    if (exp_q.size() == 0) check(1'b0, "unexpected event", ev, -1);
    else begin
      int e;
      e = exp_q.pop_front();
      check(e == ev, "event order", ev, e);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      quiet++;
      if (result_valid_o) n_res++;
      if (conv_abort_o) begin pop_cmp(EV_ABORT); quiet = 0; end
      if (seq_drop_o)   begin pop_cmp(EV_DROP);  quiet = 0; end
      if (conv_start_o) begin pop_cmp(int'(conv_cmd_o)); quiet = 0; end
    end
  end

  task automatic push(input int ev, input int rep = 1);
    for (int i = 0; i < rep; i++) exp_q.push_back(ev);
  endtask

  function automatic logic [10:0] mk_cfg(input int mode, input bit res, input bit cres, input bit nopre);
    logic [10:0] c;
    c = '0;
    c[1:0] = mode[1:0];
    c[8] = res; c[9] = cres; c[10] = nopre;
    return c;
  endfunction

  task automatic do_reset(input logic [10:0] c);
    rst_n = 1'b0; trig_i = '0; cfg_i = c;
    exp_q.delete();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    n_res = 0; quiet = 0;
  endtask

  task automatic pulse(input logic [3:0] t);
    @(posedge clk); #1 trig_i = t;
    @(posedge clk); #1 trig_i = '0;
  endtask

  task automatic fire_after(input int cmd, input logic [3:0] t);
    do @(negedge clk); while (!(conv_start_o && int'(conv_cmd_o) == cmd));
    pulse(t);
  endtask

  task automatic settle();
    do @(negedge clk); while (quiet < 40);
    check(exp_q.size() == 0, "missing events", exp_q.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state
    cur_req = "R1";
    do_reset(mk_cfg(2, 0, 0, 0));
    repeat (5) begin
      @(negedge clk);
      check(!conv_start_o && !conv_abort_o && !result_valid_o && !seq_drop_o,
            "idle strobes", {conv_start_o, conv_abort_o, result_valid_o, seq_drop_o}, 0);
    end

    // R2 R3 R12: triggers 1 and 3 together; 3 never interrupts 1
    cur_req = "R2_R3_R12";
    push(4); push(5, 6); push(6); push(12);
    pulse(4'b1010);
    settle();
    check(n_res == 9, "result count", n_res, 9);

    // R4 R8: mode 0, resume off
    cur_req = "R4_R8";
    do_reset(mk_cfg(0, 0, 0, 0));
    push(8); push(EV_ABORT); push(EV_DROP); push(0); push(1);
    pulse(4'b0100);
    fire_after(8, 4'b0001);
    settle();
    check(n_res == 2, "no result from aborted", n_res, 2);

    // R5 R9: mode 1, restart from first command
    cur_req = "R5_R9";
    do_reset(mk_cfg(1, 1, 0, 0));
    push(4); push(5, 2); push(0); push(1); push(4); push(5, 6); push(6);
    pulse(4'b0010);
    fire_after(5, 4'b0001);
    settle();

    // R6 R10: mode 2, resume after completed command
    cur_req = "R6_R10";
    do_reset(mk_cfg(2, 1, 1, 0));
    push(4); push(5, 6); push(0); push(1); push(6);
    pulse(4'b0010);
    fire_after(5, 4'b0001);
    settle();

    // R10: mode 0, resume at interrupted command
    cur_req = "R10_R4";
    do_reset(mk_cfg(0, 1, 1, 0));
    push(4); push(5); push(EV_ABORT); push(0); push(1); push(5, 6); push(6);
    pulse(4'b0010);
    fire_after(5, 4'b0001);
    settle();

    // R7: preemption disabled
    cur_req = "R7";
    do_reset(mk_cfg(0, 1, 0, 1));
    push(8, 2); push(9); push(0); push(1);
    pulse(4'b0100);
    fire_after(8, 4'b0001);
    settle();
    check(n_res == 5, "results with preemption off", n_res, 5);

    // R11: single saved level, second preemption queued
    cur_req = "R11";
    do_reset(mk_cfg(0, 1, 0, 0));
    push(8); push(EV_ABORT); push(4); push(5, 6); push(6); push(0); push(1);
    push(8, 2); push(9);
    pulse(4'b0100);
    fire_after(8, 4'b0010);
    fire_after(4, 4'b0001);
    settle();

    // R6 R8: reserved mode 3 behaves as whole-command mode, drop
    cur_req = "R6_R8_mode3";
    do_reset(mk_cfg(3, 0, 0, 0));
    push(4); push(5, 6); push(EV_DROP); push(0); push(1);
    pulse(4'b0010);
    fire_after(5, 4'b0001);
    settle();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule